// File: doc/BRIEF.md
# DDR SDRAM Initialization and Refresh Sequencer

This block runs on the memory controller side. It brings a DDR SDRAM from power-up to a usable state and then keeps it refreshed. After reset it raises the clock enable and waits out a power-up interval. It then precharges every bank and waits the row-precharge time. Next it writes the extended mode register to turn the delay-locked loop on, and after that it writes the mode register with burst, addressing and latency settings plus a DLL reset. The order is fixed: the extended register always comes before the main register, and each register write is followed by a two-clock settle before anything else may appear on the bus.

After the mode write, a lockout counter of 200 clocks has to expire before `ready` rises. Only then may the host issue reads. From the end of programming onward, an interval counter adds one owed refresh per refresh period. While a refresh is owed and the device is not still recovering from the previous one, `ref_req` is raised. The host arbiter answers with `ref_gnt` once the bus is idle, and the block then places one auto-refresh command on the bus. All timing values are given in picoseconds and converted to controller clock cycles. Minimum delays are rounded up and the refresh period is rounded down.

Cycle numbering used below: cycle k is the state of the outputs after the k-th rising edge at which `rst_n` is sampled high. P, TRP and TRFC are the power-up, precharge and refresh-recovery times in cycles. TMRD is the register-write settle time, fixed at 2 by default. DLL is the lockout length, REFI the refresh period in cycles, and CAP the maximum number of refreshes that can be owed. M = P+TRP+TMRD and R = M+TMRD. A NOP is cs_n=0, ras_n=1, cas_n=1, we_n=1 with ba=0 and addr=0.

Top module: `ddr_init_refresh_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows cke=0, a NOP, ready=0 and ref_req=0.
- R2: cke is 1 from cycle 1 on. Precharge-all appears at cycle P: cs_n=0, ras_n=0, cas_n=1, we_n=0, addr bit 10 set and every other addr bit and ba zero.
- R3: The extended mode write appears at cycle P+TRP: all four command lines low, ba=2'b01, addr bit 0 equal to the DLL-off parameter (0 = DLL on by default), all other addr bits zero.
- R4: The mode write appears at cycle M: all four command lines low, ba=2'b00, addr[2:0]=burst code, addr[3]=interleave, addr[6:4]=latency code, addr[7]=0, addr[8]=1 (DLL reset), higher bits zero. The default fields give addr=0x123.
- R5: Every cycle before R that R2–R4 do not name is a NOP. In particular, the cycle after each register write is a NOP.
- R6: ready is 0 before cycle M+DLL and is 1 from cycle M+DLL on, except inside a refresh recovery window (R9).
- R7: One refresh becomes owed at each cycle R+k·REFI (k ≥ 1). ref_req is 1 exactly when a refresh is owed, the sequencer is past cycle R-1, and no recovery window is open.
- R8: When ref_req and ref_gnt are both 1 at a rising edge, the next cycle carries an auto-refresh (cs_n=0, ras_n=0, cas_n=0, we_n=1, ba=0, addr=0) and the owed count drops by one.
- R9: During the TRFC cycles that start with the auto-refresh cycle, both ready and ref_req are 0.
- R10: ref_gnt high while ref_req is low has no effect. The bus stays NOP at every stage, including during initialization.
- R11: The owed count saturates at CAP. After a grant-free stretch covering more than CAP periods, exactly CAP refreshes are issued once grant returns, spaced TRFC+1 cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_gnt | input | 1 | Host grant: the bus is idle and a refresh may go out |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address; selects main or extended register on writes |
| addr | output | ADDR_W | Address / register operand bus |
| ready | output | 1 | Device usable for reads: lockout expired and not recovering from a refresh |
| ref_req | output | 1 | A refresh is owed and may be issued now |

## Verification
A wrong phase register or a mis-loaded gap timer moves a command on the bus. The precharge, the two register writes or the end of programming then land one or more cycles off the scheduled cycle, and this is visible at the command pins in the very cycle the command was due. A faulty lockout counter shows up as `ready` rising early or late at cycle M+DLL. A broken interval or owed counter is seen at `ref_req` within one refresh period, or as the wrong number of refreshes after a long stretch without grants. A recovery timer that is too short reopens `ref_req` inside the TRFC window right after a refresh.

// File: rtl/ddrseq_pkg.sv
// Shared types for the DDR init/refresh sequencer.
// Assumes: command pins are active low; the pin pattern per operation is fixed.
package ddrseq_pkg;

    // Operations the sequencer can place on the command bus.
    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_PREA = 3'd1,
        OP_EMRS = 3'd2,
        OP_MRS  = 3'd3,
        OP_REF  = 3'd4
    } op_e;

    // Sequencer phases, in the order they are visited.
    typedef enum logic [2:0] {
        PH_PWRUP  = 3'd0,
        PH_PRECHG = 3'd1,
        PH_EXT_WR = 3'd2,
        PH_MR_WR  = 3'd3,
        PH_RUN    = 3'd4
    } phase_e;

    // Command strobes, all active low.
    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobes_t;

    // Maps an operation to its strobe pattern.
    function automatic strobes_t strobes_for(input op_e op);
        strobes_t s;
        case (op)
            OP_PREA: s = strobes_t'(4'b0010);
            OP_EMRS: s = strobes_t'(4'b0000);
            OP_MRS:  s = strobes_t'(4'b0000);
            OP_REF:  s = strobes_t'(4'b0001);
            default: s = strobes_t'(4'b0111);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ddrseq_countdown.sv
// Loadable down-counter that stops at zero and reports when it is there.
// Assumes: load has priority over counting; the reset value fits in W bits.
module ddrseq_countdown #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt;

    // Load on request, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= W'(RST_VAL);
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/ddrseq_refresh_pacer.sv
// Refresh pacer: adds one owed refresh every REFI_CYC cycles while running,
// removes one per issued refresh, and saturates at OWED_MAX.
// Assumes: take is only asserted while pending is high.
module ddrseq_refresh_pacer #(
    parameter int REFI_CYC = 1950,
    parameter int OWED_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic take,
    output logic pending
);

    localparam int IW = (REFI_CYC > 1) ? $clog2(REFI_CYC) : 1;
    localparam int OW = $clog2(OWED_MAX + 1);

    logic [IW-1:0] ivl;
    logic [OW-1:0] owed;
    logic [OW-1:0] owed_d;
    logic [OW:0]   owed_sum;
    logic          tick;

    assign tick = run && (ivl == '0);

    // Interval counter: held at its start value until the run phase begins.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ivl <= IW'(REFI_CYC - 1);
        end else if (ivl == '0) begin
            ivl <= IW'(REFI_CYC - 1);
        end else begin
            ivl <= ivl - IW'(1);
        end
    end

    // Next owed count: add a tick, remove a take, clip at the cap.
    always_comb begin
        owed_sum = {1'b0, owed} + {{OW{1'b0}}, tick};
        if (take) begin
            owed_sum = owed_sum - (OW + 1)'(1);
        end
        if (owed_sum > (OW + 1)'(OWED_MAX)) begin
            owed_d = OW'(OWED_MAX);
        end else begin
            owed_d = owed_sum[OW-1:0];
        end
    end

    // Owed refresh register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed <= '0;
        end else begin
            owed <= owed_d;
        end
    end

    assign pending = (owed != '0);

    a_r11_owed_capped: assert property (@(posedge clk) disable iff (!rst_n)
        owed <= OW'(OWED_MAX))
        else $error("owed refresh count above cap");

    a_r7_no_take_without_debt: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (owed != '0))
        else $error("refresh taken with nothing owed");

endmodule

// File: rtl/ddrseq_cmd_drive.sv
// Registered command bus driver: turns an operation into strobes, bank and
// address operands, and raises the clock enable once out of reset.
// Assumes: ADDR_W >= 11 so the precharge-all bit exists.
module ddrseq_cmd_drive
    import ddrseq_pkg::*;
#(
    parameter int         ADDR_W     = 13,
    parameter logic [2:0] BURST_CODE = 3'b011,
    parameter logic       INTERLEAVE = 1'b0,
    parameter logic [2:0] CL_CODE    = 3'b010,
    parameter logic       DLL_OFF    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    output logic              cke,
    output strobes_t          strobes,
    output logic [1:0]        ba,
    output logic [ADDR_W-1:0] addr
);

    localparam int PREA_BIT      = 10;
    localparam int DLL_RESET_BIT = 8;
    localparam int TEST_BIT      = 7;

    logic [1:0]        ba_d;
    logic [ADDR_W-1:0] addr_d;

    // Operand selection per operation.
    always_comb begin
        ba_d   = 2'b00;
        addr_d = '0;
        case (op)
            OP_PREA: addr_d[PREA_BIT] = 1'b1;
            OP_EMRS: begin
                ba_d      = 2'b01;
                addr_d[0] = DLL_OFF;
            end
            OP_MRS: begin
                addr_d[2:0]           = BURST_CODE;
                addr_d[3]             = INTERLEAVE;
                addr_d[6:4]           = CL_CODE;
                addr_d[TEST_BIT]      = 1'b0;
                addr_d[DLL_RESET_BIT] = 1'b1;
            end
            default: begin
                ba_d   = 2'b00;
                addr_d = '0;
            end
        endcase
    end

    // Output register for the whole command bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke     <= 1'b0;
            strobes <= strobes_for(OP_NOP);
            ba      <= 2'b00;
            addr    <= '0;
        end else begin
            cke     <= 1'b1;
            strobes <= strobes_for(op);
            ba      <= ba_d;
            addr    <= addr_d;
        end
    end

endmodule

// File: rtl/ddr_init_refresh_seq.sv
// DDR SDRAM initialization and refresh sequencer.
// Power-up wait, precharge-all, extended mode write, mode write (with DLL
// reset), then paced auto-refresh under a host grant handshake. ready rises
// once the DLL lockout has run out.
// Assumes: TMRD_CYC >= 2, DLL_LOCK_CYC > TMRD_CYC, all time parameters > 0.
module ddr_init_refresh_seq
    import ddrseq_pkg::*;
#(
    parameter int         ADDR_W       = 13,
    parameter int         CLK_PS       = 8000,
    parameter int         PWRUP_PS     = 200000000,
    parameter int         TRP_PS       = 20000,
    parameter int         TRFC_PS      = 75000,
    parameter int         REFI_PS      = 15600000,
    parameter int         TMRD_CYC     = 2,
    parameter int         DLL_LOCK_CYC = 200,
    parameter int         OWED_MAX     = 8,
    parameter logic [2:0] BURST_CODE   = 3'b011,
    parameter logic       INTERLEAVE   = 1'b0,
    parameter logic [2:0] CL_CODE      = 3'b010,
    parameter logic       DLL_OFF      = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_gnt,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [1:0]        ba,
    output logic [ADDR_W-1:0] addr,
    output logic              ready,
    output logic              ref_req
);

    // Minimum delays round up; the refresh period rounds down.
    localparam int PWRUP_C = (PWRUP_PS + CLK_PS - 1) / CLK_PS;
    localparam int TRP_C   = (TRP_PS + CLK_PS - 1) / CLK_PS;
    localparam int TRFC_C  = (TRFC_PS + CLK_PS - 1) / CLK_PS;
    localparam int REFI_C  = REFI_PS / CLK_PS;
    localparam int GAP_A   = (PWRUP_C > TRP_C) ? PWRUP_C : TRP_C;
    localparam int GAP_MAX = (GAP_A > TMRD_CYC) ? GAP_A : TMRD_CYC;
    localparam int GAP_W   = $clog2(GAP_MAX + 1);
    localparam int LOCK_W  = $clog2(DLL_LOCK_CYC + 1);
    localparam int RFC_W   = $clog2(TRFC_C + 1);

    phase_e           phase;
    phase_e           phase_d;
    op_e              op;
    logic             gap_load;
    logic [GAP_W-1:0] gap_val;
    logic             gap_zero;
    logic             lock_zero;
    logic             lock_armed;
    logic             rfc_zero;
    logic             rfc_busy;
    logic             run;
    logic             pending;
    logic             ref_take;
    strobes_t         strobes;

    assign run      = (phase == PH_RUN);
    assign rfc_busy = !rfc_zero;
    assign ref_req  = run && pending && !rfc_busy;
    assign ref_take = ref_req && ref_gnt;

    // Phase sequencing: pick the command and next gap for this cycle.
    always_comb begin
        phase_d  = phase;
        op       = OP_NOP;
        gap_load = 1'b0;
        gap_val  = '0;
        case (phase)
            PH_PWRUP: if (gap_zero) begin
                op       = OP_PREA;
                phase_d  = PH_PRECHG;
                gap_load = 1'b1;
                gap_val  = GAP_W'(TRP_C - 1);
            end
            PH_PRECHG: if (gap_zero) begin
                op       = OP_EMRS;
                phase_d  = PH_EXT_WR;
                gap_load = 1'b1;
                gap_val  = GAP_W'(TMRD_CYC - 1);
            end
            PH_EXT_WR: if (gap_zero) begin
                op       = OP_MRS;
                phase_d  = PH_MR_WR;
                gap_load = 1'b1;
                gap_val  = GAP_W'(TMRD_CYC - 1);
            end
            PH_MR_WR: if (gap_zero) begin
                phase_d = PH_RUN;
            end
            PH_RUN: if (ref_take) begin
                op = OP_REF;
            end
            default: phase_d = PH_PWRUP;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_PWRUP;
        end else begin
            phase <= phase_d;
        end
    end

    // Lockout arming: set when the mode write (with DLL reset) goes out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_armed <= 1'b0;
        end else if (op == OP_MRS) begin
            lock_armed <= 1'b1;
        end
    end

    assign ready = lock_armed && lock_zero && !rfc_busy;

    ddrseq_countdown #(.W(GAP_W), .RST_VAL(PWRUP_C - 1)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .zero     (gap_zero)
    );

    ddrseq_countdown #(.W(LOCK_W), .RST_VAL(0)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (op == OP_MRS),
        .load_val (LOCK_W'(DLL_LOCK_CYC)),
        .zero     (lock_zero)
    );

    ddrseq_countdown #(.W(RFC_W), .RST_VAL(0)) u_rfc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ref_take),
        .load_val (RFC_W'(TRFC_C)),
        .zero     (rfc_zero)
    );

    ddrseq_refresh_pacer #(.REFI_CYC(REFI_C), .OWED_MAX(OWED_MAX)) u_pacer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .take    (ref_take),
        .pending (pending)
    );

    ddrseq_cmd_drive #(
        .ADDR_W     (ADDR_W),
        .BURST_CODE (BURST_CODE),
        .INTERLEAVE (INTERLEAVE),
        .CL_CODE    (CL_CODE),
        .DLL_OFF    (DLL_OFF)
    ) u_drive (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .cke     (cke),
        .strobes (strobes),
        .ba      (ba),
        .addr    (addr)
    );

    assign cs_n  = strobes.cs_n;
    assign ras_n = strobes.ras_n;
    assign cas_n = strobes.cas_n;
    assign we_n  = strobes.we_n;

    a_r2_cmd_needs_cke: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (!cs_n && ras_n && cas_n && we_n))
        else $error("command issued with cke low");

    a_r5_settle_after_modewrite: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && !cas_n && !we_n) |=> (!cs_n && ras_n && cas_n && we_n))
        else $error("command directly after register write");

    a_r8_refresh_only_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && !cas_n && we_n) |-> $past(ref_req && ref_gnt))
        else $error("refresh without granted request");

    a_r9_quiet_after_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && !cas_n && we_n) |-> (!ready && !ref_req))
        else $error("ready or request during refresh recovery");

    a_r6_ready_after_programming: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> run)
        else $error("ready before programming finished");

endmodule

// File: tb/ddr_init_refresh_seq_test.sv
// Bench: behavioural cycle model compared against the outputs every clock.
module ddr_init_refresh_seq_test;

    localparam int P    = 10;
    localparam int TRP  = 3;
    localparam int TMRD = 2;
    localparam int TRFC = 5;
    localparam int REFI = 40;
    localparam int DLL  = 200;
    localparam int CAP  = 4;
    localparam int M    = P + TRP + TMRD;
    localparam int R    = M + TMRD;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ref_gnt;
    logic        cke, cs_n, ras_n, cas_n, we_n, ready, ref_req;
    logic [1:0]  ba;
    logic [12:0] addr;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    ddr_init_refresh_seq #(
        .ADDR_W(13), .CLK_PS(8000), .PWRUP_PS(80000), .TRP_PS(20000),
        .TRFC_PS(40000), .REFI_PS(320000), .TMRD_CYC(TMRD),
        .DLL_LOCK_CYC(DLL), .OWED_MAX(CAP)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .cke(cke),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .ready(ready), .ref_req(ref_req)
    );

    // Reference model state.
    int    n = 0;
    int    owed = 0;
    int    rfc_end = 0;
    int    e_op = 0;       // 0 NOP, 1 PREA, 2 EMRS, 3 MRS, 4 REF
    bit    e_req = 0, e_rdy = 0, e_cke = 0, busy = 0, armed = 0;

    // Model step on every rising edge.
    always @(posedge clk) begin
        bit hit, tick;
        armed = 1;
        if (!rst_n) begin
            n = 0; owed = 0; rfc_end = 0; e_op = 0;
            e_req = 0; e_rdy = 0; e_cke = 0; busy = 0;
        end else begin
            n++;
            e_cke = 1;
            hit   = e_req && ref_gnt;
            e_op  = 0;
            if (n == P)       e_op = 1;
            if (n == P + TRP) e_op = 2;
            if (n == M)       e_op = 3;
            tick = (n > R) && ((n - R) % REFI == 0);
            owed = owed + int'(tick) - int'(hit);
            if (owed > CAP) owed = CAP;
            if (hit) begin
                e_op = 4;
                rfc_end = n + TRFC;
            end
            busy  = n < rfc_end;
            e_req = (n >= R) && (owed > 0) && !busy;
            e_rdy = (n >= M + DLL) && !busy;
        end
    end

    // Compare all outputs away from the active edge.
    always @(negedge clk) begin
        if (armed) begin
            logic [3:0]  x_pins;
            logic [1:0]  x_ba;
            logic [12:0] x_addr;
            string       tag;
            case (e_op)
                1: begin x_pins = 4'b0010; x_ba = 2'b00; x_addr = 13'h400; tag = "R2"; end
                2: begin x_pins = 4'b0000; x_ba = 2'b01; x_addr = 13'h000; tag = "R3"; end
                3: begin x_pins = 4'b0000; x_ba = 2'b00; x_addr = 13'h123; tag = "R4"; end
                4: begin x_pins = 4'b0001; x_ba = 2'b00; x_addr = 13'h000; tag = "R8"; end
                default: begin
                    x_pins = 4'b0111; x_ba = 2'b00; x_addr = 13'h000;
                    tag = (n == 0) ? "R1" : ((n < R) ? "R5" : "R10");
                end
            endcase
            checks++;
            if ({cke, cs_n, ras_n, cas_n, we_n, ba, addr} !== {e_cke, x_pins, x_ba, x_addr}) begin
                fails++;
                $display("FAIL %s cycle %0d: bus cke=%b pins=%b ba=%b addr=%h expected cke=%b pins=%b ba=%b addr=%h",
                         (n <= 1 && cke !== e_cke) ? "R2" : tag, n, cke,
                         {cs_n, ras_n, cas_n, we_n}, ba, addr, e_cke, x_pins, x_ba, x_addr);
            end
            checks++;
            if (ready !== e_rdy) begin
                fails++;
                $display("FAIL %s cycle %0d: ready=%b expected %b",
                         (n == 0) ? "R1" : (busy ? "R9" : "R6"), n, ready, e_rdy);
            end
            checks++;
            if (ref_req !== e_req) begin
                fails++;
                $display("FAIL %s cycle %0d: ref_req=%b expected %b",
                         (n == 0) ? "R1" : (busy ? "R9" : "R7"), n, ref_req, e_req);
            end
        end
    end

    // Wait until the model reaches a given cycle.
    task automatic wait_cycle(input int target);
        while (n < target) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired at cycle %0d", n);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Stimulus.
    initial begin
        int refs;
        rst_n   = 1'b0;
        ref_gnt = 1'b1;            // R10: grant during init must be ignored
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R7/R8: grant always available, refreshes follow each tick.
        wait_cycle(R + 4 * REFI + 5);
        ref_gnt = 1'b0;

        // R11: withhold grant across six periods, then release.
        wait_cycle(R + 10 * REFI);
        ref_gnt = 1'b1;
        refs = 0;
        for (int i = 0; i < 35; i++) begin
            @(negedge clk);
            if ({cs_n, ras_n, cas_n, we_n} === 4'b0001) refs++;
        end
        checks++;
        if (refs != CAP) begin
            fails++;
            $display("FAIL R11 refreshes after backlog: got %0d expected %0d", refs, CAP);
        end

        // R8/R9: grant arrives late in an irregular pattern.
        for (int i = 0; i < 160; i++) begin
            @(negedge clk);
            ref_gnt = ((i % 7) >= 4);
        end
        ref_gnt = 1'b1;
        repeat (60) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule